// File: doc/BRIEF.md
# High/Low Count Programmable Clock Divider

This block divides an input clock by an integer ratio from 1 to 128. The ratio is not held as one number. It is held as a high-time count, a low-time count, a half-period edge bit and a bypass bit, the fields a clock-tile output counter uses. The output stays high for the high count and low for the low count, both counted in input cycles. When the edge bit is set, a stage clocked on the falling edge stretches the high time by half an input period, so odd ratios come out at 50% duty. The bypass bit passes the input clock straight through.

The configuration comes from one of two sources. The first is a raw counter word. The second is an integer ratio, which a built-in encoder splits into the four fields. A new configuration takes effect only at the end of a complete output period, so a change never produces a shortened pulse. The block reports the ratio it is currently running, in registered form, on a readback port.

Top module: `hl_clk_divider`

## Requirements
- R1: While reset is high, `clk_div_o` is 0 and `ratio_o` is 0.
- R2: An integer ratio of 0 or 1 selects bypass: `clk_div_o` follows `clk_i` (5 ns high, 5 ns low at a 10 ns input period) and `ratio_o` reads 1.
- R3: For an integer ratio N from 2 to 128, the encoder sets high = floor(N/2), low = N − high and edge = N mod 2. For even N, the output is high for N/2 input cycles and then low for N/2 input cycles.
- R4: For odd N, the output high time and low time are each N/2 input periods, which gives 50% duty.
- R5: The raw word layout is: bits 5:0 low count, bits 11:6 high count, bit 12 bypass, bit 13 edge. Without bypass, the output is high for high + 0.5·edge input cycles and low for low − 0.5·edge input cycles.
- R6: A high or low field of 0, with the bypass bit clear, counts as 64.
- R7: `ratio_o` reads high + low of the configuration in force, or 1 in bypass. It changes on the same clock edge that the configuration takes effect.
- R8: A configuration change during an output period does not take effect until that period has run to its end with its old high and low times.
- R9: An integer ratio above 128 is treated as 128.
- R10: `use_int_i` = 1 selects the integer path, and `use_int_i` = 0 selects the raw word. The input that is not selected has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Input clock to be divided |
| rst_i | input | 1 | Synchronous active-high reset |
| use_int_i | input | 1 | 1: integer ratio source, 0: raw word source |
| div_int_i | input | 8 | Integer divide ratio |
| cfg_raw_i | input | 14 | Raw counter word (edge, bypass, high, low) |
| clk_div_o | output | 1 | Divided clock |
| ratio_o | output | 8 | Ratio currently in force |

## Verification
A configuration change and the end of the current output period can fall on the same edge. Whether the old or the new counts govern the next pulse depends on that edge. The bench provokes this by starting a ratio-20 high pulse, switching the integer input to 4 three cycles into the pulse, and timing the pulse and the following low phase. Both must keep their full 100 ns. Only the pulse after that may show the new 20 ns high time, and the readback must change at that boundary.

// File: rtl/hld_pkg.sv
package hld_pkg;
  localparam int HLD_FIELD_W = 6;

  typedef enum logic {
    PH_LOW  = 1'b0,
    PH_HIGH = 1'b1
  } phase_e;
endpackage

// File: rtl/hld_encode.sv
module hld_encode #(
  parameter int W = hld_pkg::HLD_FIELD_W,
  localparam int RW = W + 2,
  localparam int CW = 2 * W + 2
) (
  input  logic [RW-1:0] n_i,
  output logic [CW-1:0] word_o
);
  localparam logic [RW-1:0] MAXN = {2'b10, {W{1'b0}}};

  logic [RW-1:0] n_sat;
  logic [RW-1:0] hi_v;
  logic [RW-1:0] lo_v;

  always_comb begin
    n_sat  = (n_i > MAXN) ? MAXN : n_i;
    hi_v   = n_sat >> 1;
    lo_v   = n_sat - hi_v;
    word_o = '0;
    if (n_sat <= RW'(1)) begin
      word_o[2*W] = 1'b1;
    end else begin
      word_o[W-1:0]   = lo_v[W-1:0];
      word_o[2*W-1:W] = hi_v[W-1:0];
      word_o[2*W+1]   = n_sat[0];
    end
    if (n_sat > RW'(1)) begin
      AST_ENC_SPLIT: assert ((hi_v + lo_v) == n_sat && (lo_v - hi_v) <= RW'(1)); // R3
    end
  end
endmodule

// File: rtl/hld_core.sv
module hld_core #(
  parameter int W = hld_pkg::HLD_FIELD_W,
  localparam int CTW = W + 1,
  localparam int RW = W + 2,
  localparam int CW = 2 * W + 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic [CW-1:0] cfg_i,
  output logic          ph_hi_o,
  output logic          edge_o,
  output logic          nc_o,
  output logic [RW-1:0] ratio_o
);
  import hld_pkg::*;

  localparam logic [CTW-1:0] FULL = {1'b1, {W{1'b0}}};

  logic [W-1:0]   f_lo, f_hi;
  logic           f_nc, f_edge;
  logic [CTW-1:0] dec_lo, dec_hi;
  logic [RW-1:0]  new_ratio;

  phase_e         ph;
  logic [CTW-1:0] cnt;
  logic [CTW-1:0] act_hi, act_lo;
  logic           act_edge, act_nc;
  logic           load_pend;
  logic [RW-1:0]  ratio_q;
  logic           period_end;

  always_comb begin
    f_lo      = cfg_i[W-1:0];
    f_hi      = cfg_i[2*W-1:W];
    f_nc      = cfg_i[2*W];
    f_edge    = cfg_i[2*W+1];
    dec_lo    = (f_lo == '0) ? FULL : {1'b0, f_lo};
    dec_hi    = (f_hi == '0) ? FULL : {1'b0, f_hi};
    new_ratio = f_nc ? RW'(1) : ({1'b0, dec_hi} + {1'b0, dec_lo});
  end

  assign period_end = act_nc || ((ph == PH_LOW) && (cnt == act_lo));

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ph        <= PH_LOW;
      cnt       <= '0;
      act_hi    <= '0;
      act_lo    <= '0;
      act_edge  <= 1'b0;
      act_nc    <= 1'b0;
      load_pend <= 1'b1;
      ratio_q   <= '0;
    end else if (load_pend || period_end) begin
      act_hi    <= dec_hi;
      act_lo    <= dec_lo;
      act_edge  <= f_edge & ~f_nc;
      act_nc    <= f_nc;
      ratio_q   <= new_ratio;
      ph        <= PH_HIGH;
      cnt       <= CTW'(1);
      load_pend <= 1'b0;
    end else if ((ph == PH_HIGH) && (cnt == act_hi)) begin
      ph  <= PH_LOW;
      cnt <= CTW'(1);
    end else begin
      cnt <= cnt + CTW'(1);
    end
  end

  assign ph_hi_o = (ph == PH_HIGH);
  assign edge_o  = act_edge;
  assign nc_o    = act_nc;
  assign ratio_o = ratio_q;

  AST_HIGH_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_pend && !act_nc && ph == PH_HIGH) |-> (cnt >= CTW'(1) && cnt <= act_hi)); // R3
  AST_LOW_LEN: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_pend && !act_nc && ph == PH_LOW) |-> (cnt >= CTW'(1) && cnt <= act_lo)); // R5
  AST_CFG_HOLD: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_pend && !period_end) |=> ($stable(act_hi) && $stable(act_lo)
      && $stable(act_edge) && $stable(act_nc) && $stable(ratio_q))); // R8
  AST_BYPASS_RATIO: assert property (@(posedge clk_i) disable iff (rst_i)
    (!load_pend && act_nc) |-> (ratio_q == RW'(1))); // R7
endmodule

// File: rtl/hld_halfstage.sv
module hld_halfstage (
  input  logic clk_i,
  input  logic rst_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(negedge clk_i) begin
    if (rst_i) q_o <= 1'b0;
    else       q_o <= d_i;
  end
endmodule

// File: rtl/hl_clk_divider.sv
module hl_clk_divider #(
  parameter int W = hld_pkg::HLD_FIELD_W,
  localparam int RW = W + 2,
  localparam int CW = 2 * W + 2
) (
  input  logic          clk_i,
  input  logic          rst_i,
  input  logic          use_int_i,
  input  logic [RW-1:0] div_int_i,
  input  logic [CW-1:0] cfg_raw_i,
  output logic          clk_div_o,
  output logic [RW-1:0] ratio_o
);
  logic [CW-1:0] enc_word;
  logic [CW-1:0] cfg_sel;
  logic          ph_hi, edge_en, nc_en, ph_hi_neg;

  hld_encode #(.W(W)) u_enc (
    .n_i    (div_int_i),
    .word_o (enc_word)
  );

  assign cfg_sel = use_int_i ? enc_word : cfg_raw_i;

  hld_core #(.W(W)) u_core (
    .clk_i   (clk_i),
    .rst_i   (rst_i),
    .cfg_i   (cfg_sel),
    .ph_hi_o (ph_hi),
    .edge_o  (edge_en),
    .nc_o    (nc_en),
    .ratio_o (ratio_o)
  );

  hld_halfstage u_half (
    .clk_i (clk_i),
    .rst_i (rst_i),
    .d_i   (ph_hi),
    .q_o   (ph_hi_neg)
  );

  assign clk_div_o = nc_en ? clk_i : (ph_hi | (edge_en & ph_hi_neg));

  AST_RESET_RATIO: assert property (@(posedge clk_i)
    $past(rst_i) |-> (ratio_o == '0)); // R1
endmodule

// File: tb/hl_clk_divider_tb_top.sv
`timescale 1ns/1ps
module hl_clk_divider_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        use_int = 1'b1;
  logic [7:0]  div_int = 8'd1;
  logic [13:0] cfg_raw = '0;
  logic        clk_div;
  logic [7:0]  ratio;

  int n_chk = 0;
  int n_bad = 0;

  typedef struct {
    string tag;
    int    ratio;
    int    hi_ps;
    int    lo_ps;
  } exp_t;
  exp_t sb_q[$];

  always #5 clk = ~clk;

  hl_clk_divider dut_i (
    .clk_i     (clk),
    .rst_i     (rst),
    .use_int_i (use_int),
    .div_int_i (div_int),
    .cfg_raw_i (cfg_raw),
    .clk_div_o (clk_div),
    .ratio_o   (ratio)
  );

  task automatic check(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int to_ps(realtime t);
    return int'(t * 1000.0);
  endfunction

  task automatic drive(string tag, logic ui, logic [7:0] n, logic [13:0] raw,
                       int r, int hi_ps, int lo_ps);
    exp_t e;
    use_int = ui;
    div_int = n;
    cfg_raw = raw;
    e.tag = tag; e.ratio = r; e.hi_ps = hi_ps; e.lo_ps = lo_ps;
    sb_q.push_back(e);
  endtask

  task automatic monitor_one();
    exp_t e;
    realtime t0, t1, t2;
    e = sb_q.pop_front();
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      if (ratio == e.ratio[7:0]) break;
    end
    check({e.tag, " ratio R7"}, int'(ratio), e.ratio);
    @(posedge clk_div); t0 = $realtime;
    @(negedge clk_div); t1 = $realtime;
    @(posedge clk_div); t2 = $realtime;
    check({e.tag, " high"}, to_ps(t1 - t0), e.hi_ps);
    check({e.tag, " low"}, to_ps(t2 - t1), e.lo_ps);
  endtask

  initial begin
    realtime t0, t1, t2, t3;
    repeat (4) @(negedge clk);
    check("R1 clk_div in reset", int'(clk_div), 0);
    check("R1 ratio in reset", int'(ratio), 0);
    @(negedge clk);
    rst = 1'b0;

    // R2 R3 R4: every integer ratio, half-period high and low each
    for (int n = 1; n <= 128; n++) begin
      drive($sformatf("R3/R4 N=%0d", n), 1'b1, 8'(n), 14'h0, n, n * 5000, n * 5000);
      monitor_one();
    end

    // R6 R10: raw high field 0 -> 64, low 5; integer input ignored
    drive("R6/R10 zero high", 1'b0, 8'd50, {1'b0, 1'b0, 6'd0, 6'd5}, 69, 640000, 50000);
    monitor_one();

    // R5: raw edge set with high 3, low 5
    drive("R5 raw edge", 1'b0, 8'd50, {1'b1, 1'b0, 6'd3, 6'd5}, 8, 35000, 45000);
    monitor_one();

    // R2: integer 0 is bypass
    drive("R2 int zero", 1'b1, 8'd0, 14'h0, 1, 5000, 5000);
    monitor_one();

    drive("R3 N=20", 1'b1, 8'd20, 14'h0, 20, 100000, 100000);
    monitor_one();

    // R2 R5: raw bypass bit overrides nonzero counts
    drive("R2/R5 raw bypass", 1'b0, 8'd9, {1'b1, 1'b1, 6'd7, 6'd9}, 1, 5000, 5000);
    monitor_one();

    // R9: saturation
    drive("R9 N=200", 1'b1, 8'd200, 14'h0, 128, 640000, 640000);
    monitor_one();

    // R8: change mid-pulse, old period completes
    drive("R8 setup N=20", 1'b1, 8'd20, 14'h0, 20, 100000, 100000);
    monitor_one();
    @(posedge clk_div); t0 = $realtime;
    repeat (3) @(negedge clk);
    div_int = 8'd4;
    @(negedge clk_div); t1 = $realtime;
    check("R8 old high kept", to_ps(t1 - t0), 100000);
    @(negedge clk);
    check("R8 ratio held mid-period", int'(ratio), 20);
    @(posedge clk_div); t2 = $realtime;
    check("R8 old low kept", to_ps(t2 - t1), 100000);
    @(negedge clk_div); t3 = $realtime;
    check("R8 new high", to_ps(t3 - t2), 20000);
    check("R8 R7 ratio new", int'(ratio), 4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(200000 * 10);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog actual=timeout expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule